// File: doc/BRIEF.md
# SDRAM Mode Register Shadow

This block keeps a local copy of the four SDRAM mode registers and turns each host write into a load-mode command for the memory. A small register bus selects one register with a 2-bit index and carries a 12-bit value. The index codes are 0 for the standard mode register, 1 for extended register 0 (DDR extended mode), 2 for extended register 1 (low-power options such as partial-array or temperature-compensated self-refresh) and 3 for extended register 2 (reserved for later use). A host read returns the stored copy of the selected register and never reaches the device.

When a write is accepted, the block raises a command request. The request carries the register index and the whole 12-bit value, so option bits that later devices add are also passed on. The request stays up until the command path acknowledges it. During that time `host_ready` is low and further writes are held off.

Every accepted write is also checked against the rules for the device type chosen by `dev_type`. A write that breaks a rule is still stored and still issued. It also sets a sticky error flag, so that software can see the mistake.

Top module: `sdram_mode_shadow`

## Requirements
- R1: After reset, all four stored registers read as zero, `cmd_req` and `rule_err` are 0, and `host_ready` is 1.
- R2: A write is accepted when `host_wr` and `host_ready` are both 1 at a clock edge. The value is stored in the register selected by `host_sel` and can be read from the next cycle on. The other three registers keep their values.
- R3: In the cycle after a write is accepted, `cmd_req` is 1, `cmd_idx` equals the `host_sel` of that write, and `cmd_val` equals its full 12-bit value.
- R4: While `cmd_req` is 1 and `cmd_ack` is 0, `cmd_req`, `cmd_idx` and `cmd_val` stay unchanged. In the cycle after `cmd_ack` is sampled high with `cmd_req` high, `cmd_req` is 0.
- R5: While a command is pending, `host_ready` is 0. A `host_wr` in that time changes no stored register and does not alter the pending command.
- R6: `host_rdata` shows the stored value of the register selected by `host_sel` in the same cycle. Reads have no effect on commands or on stored state.
- R7: With `dev_type` = 0 (single data rate), a write to index 0 whose burst-length field, bits [2:0], is not 3'b111 (full page) sets `rule_err`.
- R8: With `dev_type` = 1 (mobile DDR), a write to index 0 sets `rule_err` in either of two cases: the burst-length field, bits [2:0], is not 3'b011 (length 8), or the CAS latency field, bits [6:4], is not 3'b011 (latency 3).
- R9: A write with a non-zero reserved bit sets `rule_err`. The reserved bits are [11:7] for index 0, [11:2] for index 1, [11:7] for index 2, and all bits for index 3.
- R10: `rule_err` becomes 1 in the cycle after a violating write is accepted and stays 1 until reset. The violating value is still stored and issued as in R2 and R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_type | input | 1 | Device type: 0 single data rate, 1 mobile DDR |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register index for reads and writes |
| host_wdata | input | 12 | Host write value |
| host_ready | output | 1 | High when a write can be accepted |
| host_rdata | output | 12 | Stored value of the selected register |
| cmd_req | output | 1 | Load-mode command request |
| cmd_idx | output | 2 | Register index of the pending command |
| cmd_val | output | 12 | Value of the pending command |
| cmd_ack | input | 1 | Acknowledge from the command path |
| rule_err | output | 1 | Sticky flag for a write that broke a rule |

## Verification
Two things can meet in one cycle: the acknowledge that ends a pending command, and a host write that is still being stalled. A host read can also fall in the same cycle as that write. The bench holds `host_wr` high with a different register and value while the request is outstanding, and it acknowledges after a random delay that is sometimes zero. It then checks that the pending index and value did not move and that every stored register still matches the bench's model. After the acknowledge, it checks that the next write gets through with its own value and no mix of the two.

// File: rtl/sms_pkg.sv
package sms_pkg;

    localparam int VAL_W  = 12;
    localparam int NUM_MR = 4;
    localparam int IDX_W  = $clog2(NUM_MR);

    localparam logic [2:0] BL_FULL_PAGE = 3'b111;
    localparam logic [2:0] BL_EIGHT     = 3'b011;
    localparam logic [2:0] CL_THREE     = 3'b011;

    typedef enum logic [IDX_W-1:0] {
        MR_STD  = 2'd0,
        MR_EXT0 = 2'd1,
        MR_EXT1 = 2'd2,
        MR_EXT2 = 2'd3
    } mr_sel_e;

    typedef enum logic {
        DEV_SDR  = 1'b0,
        DEV_MDDR = 1'b1
    } dev_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] val;
    } mr_cmd_t;

    function automatic logic [VAL_W-1:0] reserved_mask(mr_sel_e sel);
        logic [VAL_W-1:0] m;
        case (sel)
            MR_STD:  m = 12'hF80;
            MR_EXT0: m = 12'hFFC;
            MR_EXT1: m = 12'hF80;
            default: m = 12'hFFF;
        endcase
        return m;
    endfunction

    function automatic logic rule_violation(mr_sel_e sel, logic [VAL_W-1:0] v, dev_e dev);
        logic bad;
        bad = |(v & reserved_mask(sel));
        if (sel == MR_STD) begin
            if (dev == DEV_SDR)
                bad = bad | (v[2:0] != BL_FULL_PAGE);
            else
                bad = bad | (v[2:0] != BL_EIGHT) | (v[6:4] != CL_THREE);
        end
        return bad;
    endfunction

endpackage

// File: rtl/sms_regfile.sv
module sms_regfile
    import sms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VAL_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VAL_W-1:0] rd_val
);
    logic [VAL_W-1:0] regs [NUM_MR];

    for (genvar g = 0; g < NUM_MR; g++) begin : g_mr
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                regs[g] <= wr_val;
        end
    end

    assign rd_val = regs[rd_idx];
endmodule

// File: rtl/sms_rule_check.sv
module sms_rule_check
    import sms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic [VAL_W-1:0] chk_val,
    input  logic             dev_sel,
    output logic             err_sticky
);
    logic viol;

    always_comb viol = rule_violation(mr_sel_e'(chk_idx), chk_val, dev_e'(dev_sel));

    always_ff @(posedge clk) begin
        if (rst)
            err_sticky <= 1'b0;
        else if (chk_en && viol)
            err_sticky <= 1'b1;
    end
endmodule

// File: rtl/sms_cmd_issue.sv
module sms_cmd_issue
    import sms_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  mr_cmd_t load_cmd,
    input  logic    ack,
    output logic    req,
    output mr_cmd_t cmd,
    output logic    idle
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            cmd <= '0;
        end else if (!req && load) begin
            req <= 1'b1;
            cmd <= load_cmd;
        end else if (req && ack) begin
            req <= 1'b0;
        end
    end

    assign idle = !req;
endmodule

// File: rtl/sdram_mode_shadow.sv
module sdram_mode_shadow
    import sms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             dev_type,
    input  logic             host_wr,
    input  logic [IDX_W-1:0] host_sel,
    input  logic [VAL_W-1:0] host_wdata,
    output logic             host_ready,
    output logic [VAL_W-1:0] host_rdata,
    output logic             cmd_req,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [VAL_W-1:0] cmd_val,
    input  logic             cmd_ack,
    output logic             rule_err
);
    logic    accept;
    logic    idle;
    mr_cmd_t new_cmd;
    mr_cmd_t cur_cmd;

    assign accept  = host_wr && idle;
    assign new_cmd = '{idx: host_sel, val: host_wdata};

    sms_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (accept),
        .wr_idx (host_sel),
        .wr_val (host_wdata),
        .rd_idx (host_sel),
        .rd_val (host_rdata)
    );

    sms_rule_check u_rules (
        .clk        (clk),
        .rst        (rst),
        .chk_en     (accept),
        .chk_idx    (host_sel),
        .chk_val    (host_wdata),
        .dev_sel    (dev_type),
        .err_sticky (rule_err)
    );

    sms_cmd_issue u_issue (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_cmd (new_cmd),
        .ack      (cmd_ack),
        .req      (cmd_req),
        .cmd      (cur_cmd),
        .idle     (idle)
    );

    assign host_ready = idle;
    assign cmd_idx    = cur_cmd.idx;
    assign cmd_val    = cur_cmd.val;
endmodule

// File: rtl/sms_checker.sv
module sms_checker
    import sms_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic [IDX_W-1:0] host_sel,
    input logic [VAL_W-1:0] host_wdata,
    input logic             host_ready,
    input logic [VAL_W-1:0] host_rdata,
    input logic             cmd_req,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [VAL_W-1:0] cmd_val,
    input logic             cmd_ack,
    input logic             rule_err
);
    p_issue_r3: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_ready |=> cmd_req && cmd_idx == $past(host_sel) && cmd_val == $past(host_wdata));

    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_ready |=> (host_sel != $past(host_sel)) || (host_rdata == $past(host_wdata)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_req && !cmd_ack |=> cmd_req && $stable(cmd_idx) && $stable(cmd_val));

    p_drop_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_req && cmd_ack |=> !cmd_req);

    p_stall_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> !host_ready);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        rule_err |=> rule_err);
endmodule

bind sdram_mode_shadow sms_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .cmd_req    (cmd_req),
    .cmd_idx    (cmd_idx),
    .cmd_val    (cmd_val),
    .cmd_ack    (cmd_ack),
    .rule_err   (rule_err)
);

// File: tb/sdram_mode_shadow_test.sv
`timescale 1ns/1ps
module sdram_mode_shadow_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        dev_type;
    logic        host_wr;
    logic [1:0]  host_sel;
    logic [11:0] host_wdata;
    logic        host_ready;
    logic [11:0] host_rdata;
    logic        cmd_req;
    logic [1:0]  cmd_idx;
    logic [11:0] cmd_val;
    logic        cmd_ack;
    logic        rule_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [11:0] model [4];
    logic        err_m;

    always #10 clk = ~clk;

    sdram_mode_shadow uut (
        .clk(clk), .rst(rst), .dev_type(dev_type), .host_wr(host_wr),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .cmd_req(cmd_req), .cmd_idx(cmd_idx),
        .cmd_val(cmd_val), .cmd_ack(cmd_ack), .rule_err(rule_err)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit breaks_rule(logic [1:0] sel, logic [11:0] v, logic dev);
        case (sel)
            2'd0: begin
                if (v[11:7] != 0) return 1;
                if (!dev) return v[2:0] != 3'b111;
                return !(v[2:0] == 3'b011 && v[6:4] == 3'b011);
            end
            2'd1:    return v[11:2] != 0;
            2'd2:    return v[11:7] != 0;
            default: return v != 0;
        endcase
    endfunction

    function automatic logic [11:0] legal_value(logic [1:0] sel, logic dev, logic [31:0] r);
        case (sel)
            2'd0:    return dev ? {5'b0, 3'b011, r[3], 3'b011} : {5'b0, r[6:4], r[3], 3'b111};
            2'd1:    return {10'b0, r[1:0]};
            2'd2:    return {5'b0, r[6:0]};
            default: return 12'h000;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; host_wr = 0; cmd_ack = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 4; i++) model[i] = '0;
        err_m = 0;
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 4; i++) begin
            host_sel = i[1:0];
            #1;
            check(tag, {20'b0, host_rdata}, {20'b0, model[i]});
        end
    endtask

    task automatic do_write(logic [1:0] sel, logic [11:0] v, int delay, bit try_stall);
        while (!host_ready) @(negedge clk);
        host_sel = sel; host_wdata = v; host_wr = 1;
        @(posedge clk);
        @(negedge clk);
        host_wr = 0;
        model[sel] = v;
        if (breaks_rule(sel, v, dev_type)) err_m = 1;
        check("R3 cmd_req", {31'b0, cmd_req}, 1);
        check("R3 cmd_idx", {30'b0, cmd_idx}, {30'b0, sel});
        check("R3 cmd_val", {20'b0, cmd_val}, {20'b0, v});
        check("R5 host_ready low", {31'b0, host_ready}, 0);
        check("R7/R8/R9/R10 rule_err", {31'b0, rule_err}, {31'b0, err_m});
        host_sel = sel;
        #1;
        check("R2 readback", {20'b0, host_rdata}, {20'b0, v});
        for (int d = 0; d < delay; d++) begin
            if (try_stall && d == 0) begin
                host_sel = sel + 2'd1;
                host_wdata = ~v;
                host_wr = 1;
            end
            @(posedge clk);
            @(negedge clk);
            host_wr = 0;
            check("R4 held req", {31'b0, cmd_req}, 1);
            check("R4 held val", {18'b0, cmd_idx, cmd_val}, {18'b0, sel, v});
        end
        if (try_stall) read_all("R5 stalled write ignored");
        cmd_ack = 1;
        if (try_stall) begin
            host_sel = sel + 2'd2; host_wdata = 12'h5A5; host_wr = 1;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_ack = 0; host_wr = 0;
        check("R4 req drop", {31'b0, cmd_req}, 0);
        check("R4 ready back", {31'b0, host_ready}, 1);
        read_all("R6 read all");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h1357));
        dev_type = 0; host_sel = 0; host_wdata = 0; host_wr = 0; cmd_ack = 0; rst = 1;
        do_reset();
        // R1 reset state
        check("R1 cmd_req", {31'b0, cmd_req}, 0);
        check("R1 rule_err", {31'b0, rule_err}, 0);
        check("R1 host_ready", {31'b0, host_ready}, 1);
        read_all("R1 zero shadows");

        // legal writes under both device types, no error expected
        for (int k = 0; k < 40; k++) begin
            r = $urandom;
            dev_type = r[8];
            do_write(r[10:9], legal_value(r[10:9], r[8], r), int'(r[13:11]) % 4, r[14]);
        end
        check("R7/R8 legal keeps rule_err low", {31'b0, rule_err}, 0);

        // R7: SDR with burst length 8 is illegal
        do_reset(); dev_type = 0;
        do_write(2'd0, 12'h033, 1, 0);
        check("R7 sdr burst", {31'b0, rule_err}, 1);

        // R8: mobile DDR with CAS 2
        do_reset(); dev_type = 1;
        do_write(2'd0, 12'h023, 0, 0);
        check("R8 mddr cas", {31'b0, rule_err}, 1);
        do_reset(); dev_type = 1;
        do_write(2'd0, 12'h037, 0, 0);
        check("R8 mddr burst", {31'b0, rule_err}, 1);

        // R9: reserved bits
        do_reset(); dev_type = 0;
        do_write(2'd3, 12'h001, 0, 0);
        check("R9 ext2 reserved", {31'b0, rule_err}, 1);
        do_reset();
        do_write(2'd2, 12'h100, 2, 1);
        check("R9 ext1 reserved", {31'b0, rule_err}, 1);
        do_reset();
        do_write(2'd1, 12'h004, 0, 0);
        check("R9 ext0 reserved", {31'b0, rule_err}, 1);

        // R10: sticky through later legal writes
        do_write(2'd1, 12'h002, 1, 0);
        check("R10 sticky", {31'b0, rule_err}, 1);

        // random mix with occasional violations
        do_reset();
        for (int k = 0; k < 120; k++) begin
            r = $urandom;
            dev_type = r[8];
            if (r[20:16] == 0)
                do_write(r[10:9], r[31:20], int'(r[13:11]) % 5, r[14]);
            else
                do_write(r[10:9], legal_value(r[10:9], r[8], r), int'(r[13:11]) % 5, r[14]);
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule